// File: doc/BRIEF.md
# Single-Precision Float Comparator

This block takes two 32-bit single-precision floating-point words and a 3-bit operation code. It answers one of three questions: is the first operand greater than, equal to, or less than the second. The answer is a 32-bit word that holds 1 or 0 and is registered one clock after the inputs are presented. It uses the same code space as the integer compare path, so a shared decoder can route a compare to either unit.

The sign bit is removed from each operand. The remaining 31 bits, the biased exponent and then the fraction, are compared as one unsigned integer. Because the exponent is biased, this gives the correct order of magnitudes. The result is then corrected from the two sign bits. When both operands are negative, the magnitude order is reversed. When the signs differ, the positive operand is the greater one. Three cases override this path: a NaN operand, a pair of zeros, and an operation code that is not a compare.

Top module: `fp_compare_unit`

## Requirements
- R1: A word is NaN when bits 30:23 are all ones and bits 22:0 are not all zero. If either operand is NaN, every operation code gives a result of 0.
- R2: Operation code 3'b110 asks "a greater than b", 3'b100 asks "a equal to b" and 3'b101 asks "a less than b". Every other code (000, 001, 010, 011, 111) gives a result of 0.
- R3: When the sign bits (bit 31, where 1 means negative) differ and the operands are not both zero, the operand with sign 0 is the greater one.
- R4: When both operands are positive, they are ordered by the unsigned value of bits 30:0. Equal bits mean equal values.
- R5: When both operands are negative, the order given by the unsigned value of bits 30:0 is reversed.
- R6: +0 and -0, in any combination, compare equal. Neither is greater than or less than the other.
- R7: The answer appears in bit 0 of `result` on the clock edge after the inputs are sampled. Bits 31:1 are always 0.
- R8: A synchronous active-high `rst` clears `result` to 0.
- R9: Infinities, which have an all-ones exponent and a zero fraction, are ordered values. +inf is greater than every finite value, -inf is less than every finite value, and each infinity is equal to itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 32 | First operand, single-precision |
| opnd_b | input | 32 | Second operand, single-precision |
| cmp_op | input | 3 | Operation code |
| result | output | 32 | Boolean answer in bit 0, registered |

## Verification
The assertions assume that the operands and the operation code are steady at the sampling edge. They also assume that a result should be judged one cycle after the inputs that produced it, while `rst` is low. The stimulus changes its inputs only on falling edges and issues exactly one compare per cycle, so each sampled input set matches the result checked on the next edge. The directed patterns reach NaNs with payloads, both zeros, infinities, equal words, single-bit magnitude differences, and all eight operation codes. A random phase mixes these classes of operands.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    // Operation codes shared with the integer compare path
    localparam logic [2:0] OP_EQ = 3'b100;
    localparam logic [2:0] OP_LT = 3'b101;
    localparam logic [2:0] OP_GT = 3'b110;

    // Per-operand classification
    typedef struct packed {
        logic nan;
        logic zero;
        logic sign;
    } fp_flags_t;

    // Relation of operand a to operand b (all low when unordered)
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } fp_rel_t;

    function automatic logic is_cmp_op(input logic [2:0] code);
        return (code == OP_EQ) || (code == OP_LT) || (code == OP_GT);
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = W - 1
) (
    input  logic [W-1:0]     word,
    output fp_flags_t        flags,
    output logic [MAG_W-1:0] mag
);
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    always_comb begin
        expo       = word[W-2 -: EXP_W];
        frac       = word[MAN_W-1:0];
        mag        = word[MAG_W-1:0];
        flags.sign = word[W-1];
        flags.nan  = (&expo) && (|frac);
        flags.zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  fp_flags_t        fa,
    input  fp_flags_t        fb,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output fp_rel_t          rel
);
    logic mag_gt;
    logic mag_eq;

    always_comb begin
        mag_gt = (mag_a > mag_b);
        mag_eq = (mag_a == mag_b);
        rel    = '0;
        if (fa.nan || fb.nan) begin
            rel = '0;
        end else if (fa.zero && fb.zero) begin
            rel.eq = 1'b1;
        end else if (fa.sign != fb.sign) begin
            rel.gt = ~fa.sign;
            rel.lt = fa.sign;
        end else if (!fa.sign) begin
            rel.gt = mag_gt;
            rel.eq = mag_eq;
            rel.lt = ~mag_gt & ~mag_eq;
        end else begin
            rel.gt = ~mag_gt & ~mag_eq;
            rel.eq = mag_eq;
            rel.lt = mag_gt;
        end
    end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W     = 1 + EXP_W + MAN_W,
    localparam int MAG_W = W - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [2:0]   cmp_op,
    output logic [W-1:0] result
);
    logic [W-1:0]     words [2];
    fp_flags_t        flags [2];
    logic [MAG_W-1:0] mags  [2];
    fp_rel_t          rel;
    logic             hit;

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .word  (words[i]),
            .flags (flags[i]),
            .mag   (mags[i])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_ord (
        .fa    (flags[0]),
        .fb    (flags[1]),
        .mag_a (mags[0]),
        .mag_b (mags[1]),
        .rel   (rel)
    );

    always_comb begin
        unique case (cmp_op)
            OP_GT:   hit = rel.gt;
            OP_EQ:   hit = rel.eq;
            OP_LT:   hit = rel.lt;
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result <= '0;
        else     result <= {{(W-1){1'b0}}, hit};
    end

    // Port-level checks, recomputed from raw input fields
    logic nan_a_in, nan_b_in;
    assign nan_a_in = (&opnd_a[W-2 -: EXP_W]) && (|opnd_a[MAN_W-1:0]);
    assign nan_b_in = (&opnd_b[W-2 -: EXP_W]) && (|opnd_b[MAN_W-1:0]);

    AST_NAN_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (nan_a_in || nan_b_in) |=> (result == '0)); // R1

    AST_FOREIGN_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        !is_cmp_op(cmp_op) |=> (result == '0)); // R2

    AST_SIGNED_ZEROS_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (opnd_a[MAG_W-1:0] == '0 && opnd_b[MAG_W-1:0] == '0 && cmp_op == OP_EQ)
        |=> (result == {{(W-1){1'b0}}, 1'b1})); // R6

    AST_POSITIVE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmp_op == OP_GT && !opnd_a[W-1] && opnd_b[W-1] && !nan_a_in && !nan_b_in
         && (opnd_a[MAG_W-1:0] != '0 || opnd_b[MAG_W-1:0] != '0))
        |=> (result == {{(W-1){1'b0}}, 1'b1})); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result == '0)); // R8
endmodule

// File: tb/tb_fp_compare_unit.sv
`timescale 1ns/1ps
module tb_fp_compare_unit;
    localparam time T = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [2:0]  cmp_op = '0;
    logic [31:0] result;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] want;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(T/2) clk = ~clk;

    fp_compare_unit dut (
        .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .cmp_op(cmp_op), .result(result)
    );

    // Reference built from requirements: map each non-NaN word to an ordered key
    function automatic logic is_nan(input logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction

    function automatic logic [31:0] okey(input logic [31:0] x);
        if (x[30:0] == 0) return 32'h8000_0000;
        else if (x[31])   return ~x;
        else              return x | 32'h8000_0000;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op);
        logic r;
        if (is_nan(a) || is_nan(b)) r = 1'b0;
        else case (op)
            3'b110:  r = okey(a) > okey(b);
            3'b100:  r = okey(a) == okey(b);
            3'b101:  r = okey(a) < okey(b);
            default: r = 1'b0;
        endcase
        return {31'b0, r};
    endfunction

    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0; opnd_a = a; opnd_b = b; cmp_op = op;
        it.want = model(a, b, op);
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic drive_rst(input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b1;
        it.want = '0;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic all_three(input logic [31:0] a, input logic [31:0] b, input string tag);
        drive(a, b, 3'b110, tag);
        drive(a, b, 3'b100, tag);
        drive(a, b, 3'b101, tag);
    endtask

    // Monitor: one pop per clock, sampled after the edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #1ns;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                total++;
                if (result !== it.want) begin
                    bad++;
                    $display("FAIL %s: result=%h expected=%h", it.tag, result, it.want);
                end
            end
        end
    end

    initial begin
        #(T * 150000);
        bad++; total++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [31:0] P1    = 32'h3F80_0000; // +1.0
    localparam logic [31:0] P2    = 32'h4000_0000; // +2.0
    localparam logic [31:0] N1    = 32'hBF80_0000; // -1.0
    localparam logic [31:0] N2    = 32'hC000_0000; // -2.0
    localparam logic [31:0] PZ    = 32'h0000_0000;
    localparam logic [31:0] NZ    = 32'h8000_0000;
    localparam logic [31:0] PINF  = 32'h7F80_0000;
    localparam logic [31:0] NINF  = 32'hFF80_0000;
    localparam logic [31:0] QNAN  = 32'h7FC0_0000;
    localparam logic [31:0] SNAN  = 32'hFF80_0001;
    localparam logic [31:0] PMAX  = 32'h7F7F_FFFF;
    localparam logic [31:0] PSUB  = 32'h0000_0001;

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        total++;
        if (result !== '0) begin
            bad++;
            $display("FAIL R8: result=%h expected=%h", result, 32'h0);
        end

        // R4: positive ordering
        all_three(P2, P1, "R4");
        all_three(P1, P2, "R4");
        all_three(P1, P1, "R4");
        all_three(P1, P1 + 32'd1, "R4");
        all_three(PSUB, PZ, "R4");
        // R5: negative ordering reversed
        all_three(N2, N1, "R5");
        all_three(N1, N2, "R5");
        all_three(N1, N1, "R5");
        all_three(N1 + 32'd1, N1, "R5");
        // R3: mixed signs
        all_three(P1, N2, "R3");
        all_three(N1, P2, "R3");
        all_three(PZ, N1, "R3");
        all_three(NZ, PSUB, "R3");
        // R6: signed zeros
        all_three(PZ, NZ, "R6");
        all_three(NZ, PZ, "R6");
        all_three(NZ, NZ, "R6");
        // R9: infinities
        all_three(PINF, PMAX, "R9");
        all_three(NINF, N2, "R9");
        all_three(PINF, PINF, "R9");
        all_three(NINF, NINF, "R9");
        all_three(NINF, PINF, "R9");
        // R1: NaN operands
        all_three(QNAN, P1, "R1");
        all_three(P1, SNAN, "R1");
        all_three(QNAN, QNAN, "R1");
        all_three(SNAN, PINF, "R1");
        // R2: every code, including foreign ones
        for (int c = 0; c < 8; c++) begin
            drive(P2, P1, c[2:0], "R2");
            drive(P1, P1, c[2:0], "R2");
            drive(P1, P2, c[2:0], "R2");
        end
        // R7: bit 0 only, back-to-back updates each cycle
        drive(P2, P1, 3'b110, "R7");
        drive(P1, P2, 3'b110, "R7");
        drive(P2, P1, 3'b110, "R7");
        // R8: mid-run reset clears a set result
        drive_rst("R8");
        drive(P2, P1, 3'b110, "R8");
        // Random mix (R4, R5, R3)
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (k % 4 == 0) ? (ra ^ (32'h1 << (k % 32))) : $urandom;
            drive(ra, rb, 3'b100 | 3'($urandom % 3 + 0) , "R4");
        end

        @(negedge clk);
        rst = 1'b0; cmp_op = 3'b000;
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule